// File: doc/BRIEF.md
# Two-Level Translation Table Walker

The walker turns a 32-bit virtual address into a physical address. It reads first-level and second-level descriptors from memory through a simple one-word read port, then checks the access against the domain and access-permission rules. It finishes with either a translation and read/write grant flags, or a fault status byte. Before the walk starts, an address in the low 32 MB window is first moved by a per-process relocation offset.

A requester presents a virtual address, an access kind (load, store or fetch) and a user/privileged flag while `req_ready` is high. The translation-table base, domain control word, relocation offset, translation enable, the two ROM/system permission bits and the extended-page option are sampled on the same edge. The walker then issues at most two descriptor reads. It raises `done` for one cycle, and the result outputs hold their value until the next request is accepted. The walker holds no cached translations.

Top module: `xlat_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle. A request is taken on an edge where `req_valid` and `req_ready` are both high. `req_valid` is ignored while the walker is busy. `done` is a single-cycle pulse.
- R2: A virtual address below 0x0200_0000 has `pid_offset` added to it before any other step. An address at or above 0x0200_0000 is used unchanged.
- R3: With `xlat_en` low, `done` rises in the cycle after acceptance with `pa` equal to the relocated address, both grants set, no fault and no memory read.
- R4: The first-level descriptor is read from {base[31:14], va[31:20], 2'b00}.
- R5: A first-level descriptor with bits [1:0] = 0 gives fault code 5.
- R6: Descriptor bits [8:5] pick domain n. Its access value is dom_ctl[2n+1:2n]. An access value of 0 or 2 gives fault code 9 for a section (type 2) and fault code 11 for a table (type 1 coarse, type 3 fine).
- R7: A section maps to {desc[31:20], va[19:0]} with permission field desc[11:10]. A denied access gives fault code 13.
- R8: The second-level read address is {desc[31:10], va[19:12], 2'b00} for a coarse table and {desc[31:12], va[19:10], 2'b00} for a fine table.
- R9: A second-level type 0 gives fault code 7. Type 1 (64 KB) maps {desc[31:16], va[15:0]} and type 2 (4 KB) maps {desc[31:12], va[11:0]}. Both take their permission field from desc[5+2k:4+2k] with k = va[11:10]. A denied page access gives fault code 15.
- R10: Type 3 (1 KB) in a fine table maps {desc[31:10], va[9:0]} with permission desc[5:4]. In a coarse table it gives fault code 7, unless `ext_page_en` is set; then it maps as a 4 KB page with permission desc[5:4].
- R11: A domain access value of 3 grants read and write whatever the permission field holds.
- R12: For a domain access value of 1, the permission field decides. Field 3 grants all access. Field 1 grants privileged read/write and denies user access. Field 2 grants privileged read/write and user read only. Field 0 denies stores. For field 0, other accesses get read only when sys_perm = 1 and privileged, or when sys_perm = 2; any other case is denied. A fault arises only when nothing is granted.
- R13: On a fault, `fault` is set, `pa` and both grants are 0, and `fault_stat` = {domain number, code}.
- R14: `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_req_ready` is seen. A walk reads memory exactly as many times as its levels require.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_va | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_user | input | 1 | 1 for a user-mode access |
| tbl_base | input | 32 | Translation-table base |
| dom_ctl | input | 32 | Sixteen 2-bit domain access values |
| pid_offset | input | 32 | Relocation offset for the low window |
| xlat_en | input | 1 | Translation enable |
| sys_perm | input | 2 | ROM/system permission pair |
| ext_page_en | input | 1 | 1 KB entries in coarse tables map as 4 KB |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Descriptor word address |
| mem_rsp_valid | input | 1 | Descriptor word returned |
| mem_rsp_data | input | 32 | Descriptor word |
| done | output | 1 | Result valid for this cycle |
| fault | output | 1 | Result is a fault |
| pa | output | 32 | Physical address |
| prot_rd | output | 1 | Read granted |
| prot_wr | output | 1 | Write granted |
| fault_stat | output | 8 | Domain number in [7:4], code in [3:0] |

## Verification
The bench walks sections, coarse tables holding 64 KB, 4 KB and 1 KB entries, and fine tables holding 1 KB entries, using one virtual address whose index fields are all distinct. A wrong bit slice in either read address or in the output mapping therefore shows up. The same section descriptor is paired with every permission field, with user and privileged accesses, with loads and stores, and with each system-permission setting. This separates the grant table rows from each other, and the manager domain from the client domain. Domain faults use different domain numbers for sections and for tables, so both the code and the reported domain are checked. A stalled memory port, combined with a request that arrives while the walker is busy, shows that the address is held and that the second request is dropped.

// File: rtl/xlat_pkg.sv
// Shared types and constants for the translation table walker.
// Assumes a 32-bit virtual and physical address space with word-sized descriptors.
package xlat_pkg;
    localparam int ADDR_W  = 32;
    localparam int DOM_CNT = 16;
    localparam int DOM_IW  = $clog2(DOM_CNT);

    // Fault codes reported in fault_stat[3:0]
    localparam logic [3:0] FC_SEC_XLAT = 4'd5;
    localparam logic [3:0] FC_PG_XLAT  = 4'd7;
    localparam logic [3:0] FC_SEC_DOM  = 4'd9;
    localparam logic [3:0] FC_PG_DOM   = 4'd11;
    localparam logic [3:0] FC_SEC_PERM = 4'd13;
    localparam logic [3:0] FC_PG_PERM  = 4'd15;

    // First-level descriptor kinds
    localparam logic [1:0] L1_INVALID = 2'd0;
    localparam logic [1:0] L1_COARSE  = 2'd1;
    localparam logic [1:0] L1_SECTION = 2'd2;
    localparam logic [1:0] L1_FINE    = 2'd3;

    // Access kind encoding on req_acc
    localparam logic [1:0] ACC_STORE = 2'd1;

    typedef enum logic [2:0] {
        S_IDLE,
        S_L1_REQ,
        S_L1_WAIT,
        S_L2_REQ,
        S_L2_WAIT,
        S_DONE
    } walk_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] pa;
        logic              rd;
        logic              wr;
        logic              flt;
        logic [7:0]        stat;
    } xlat_res_t;
endpackage

// File: rtl/xlat_reloc.sv
// Process-ID relocation: adds an offset to addresses inside the low window.
// Assumes the window limit is a power-of-two boundary given by RELOC_LIMIT.
module xlat_reloc #(
    parameter int          ADDR_W      = 32,
    parameter logic [31:0] RELOC_LIMIT = 32'h0200_0000
) (
    input  logic [ADDR_W-1:0] va_in,
    input  logic [ADDR_W-1:0] offset,
    output logic [ADDR_W-1:0] va_out
);
    // Relocate only addresses below the window limit
    always_comb begin
        if (va_in < RELOC_LIMIT[ADDR_W-1:0])
            va_out = va_in + offset;
        else
            va_out = va_in;
    end
endmodule

// File: rtl/xlat_l1_decode.sv
// First-level descriptor decode: kind, domain, section mapping and table address.
// Assumes the 32-bit descriptor format with the domain number in bits [8:5].
module xlat_l1_decode
    import xlat_pkg::*;
(
    input  logic [31:0]       desc,
    input  logic [31:0]       va,
    input  logic [31:0]       dom_ctl,
    output logic [1:0]        kind,
    output logic [DOM_IW-1:0] dom_num,
    output logic [1:0]        dom_val,
    output logic [31:0]       sec_pa,
    output logic [1:0]        sec_ap,
    output logic [31:0]       l2_addr
);
    logic [1:0] dom_fld [DOM_CNT];

    // Split the domain control word into per-domain access values
    for (genvar g = 0; g < DOM_CNT; g++) begin : g_dom
        assign dom_fld[g] = dom_ctl[2*g+1 -: 2];
    end

    // Decode the fields needed by every first-level outcome
    always_comb begin
        kind    = desc[1:0];
        dom_num = desc[8:5];
        dom_val = dom_fld[desc[8:5]];
        sec_pa  = {desc[31:20], va[19:0]};
        sec_ap  = desc[11:10];
        if (desc[1:0] == L1_FINE)
            l2_addr = {desc[31:12], va[19:10], 2'b00};
        else
            l2_addr = {desc[31:10], va[19:12], 2'b00};
    end
endmodule

// File: rtl/xlat_l2_decode.sv
// Second-level descriptor decode: page size, output address and permission field.
// Assumes the caller supplies whether the descriptor came from a coarse table.
module xlat_l2_decode (
    input  logic [31:0] desc,
    input  logic [31:0] va,
    input  logic        coarse,
    input  logic        ext_en,
    output logic        xl_fault,
    output logic [31:0] pa,
    output logic [1:0]  ap
);
    logic [1:0] sub_ap;

    // Pick the permission pair of the addressed quarter page
    always_comb begin
        case (va[11:10])
            2'd0:    sub_ap = desc[5:4];
            2'd1:    sub_ap = desc[7:6];
            2'd2:    sub_ap = desc[9:8];
            default: sub_ap = desc[11:10];
        endcase
    end

    // Map by entry size, or flag a translation fault
    always_comb begin
        xl_fault = 1'b0;
        pa       = '0;
        ap       = desc[5:4];
        case (desc[1:0])
            2'd0: xl_fault = 1'b1;
            2'd1: begin
                pa = {desc[31:16], va[15:0]};
                ap = sub_ap;
            end
            2'd2: begin
                pa = {desc[31:12], va[11:0]};
                ap = sub_ap;
            end
            default: begin
                if (coarse) begin
                    if (ext_en) pa = {desc[31:12], va[11:0]};
                    else        xl_fault = 1'b1;
                end else begin
                    pa = {desc[31:10], va[9:0]};
                end
            end
        endcase
    end
endmodule

// File: rtl/xlat_perm.sv
// Access permission check from domain access value and permission field.
// Assumes stores are flagged by is_store; loads and fetches are treated alike.
module xlat_perm (
    input  logic [1:0] dom_val,
    input  logic [1:0] ap,
    input  logic       is_store,
    input  logic       user,
    input  logic [1:0] sys_perm,
    output logic       rd,
    output logic       wr
);
    // Grant table: manager domains bypass, client domains follow ap
    always_comb begin
        rd = 1'b0;
        wr = 1'b0;
        if (dom_val == 2'd3) begin
            rd = 1'b1;
            wr = 1'b1;
        end else begin
            case (ap)
                2'd0: begin
                    if (!is_store) begin
                        if (sys_perm == 2'd1)      rd = !user;
                        else if (sys_perm == 2'd2) rd = 1'b1;
                    end
                end
                2'd1: begin
                    rd = !user;
                    wr = !user;
                end
                2'd2: begin
                    rd = !user || !is_store;
                    wr = !user;
                end
                default: begin
                    rd = 1'b1;
                    wr = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/xlat_walker.sv
// Two-level translation table walker with domain and permission checks.
// Assumes one outstanding memory read and a response only after its request.
module xlat_walker
    import xlat_pkg::*;
#(
    parameter logic [31:0] RELOC_LIMIT = 32'h0200_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_va,
    input  logic [1:0]  req_acc,
    input  logic        req_user,
    input  logic [31:0] tbl_base,
    input  logic [31:0] dom_ctl,
    input  logic [31:0] pid_offset,
    input  logic        xlat_en,
    input  logic [1:0]  sys_perm,
    input  logic        ext_page_en,
    output logic        mem_req_valid,
    input  logic        mem_req_ready,
    output logic [31:0] mem_req_addr,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data,
    output logic        done,
    output logic        fault,
    output logic [31:0] pa,
    output logic        prot_rd,
    output logic        prot_wr,
    output logic [7:0]  fault_stat
);
    walk_state_e       state_q, state_d;
    logic [31:0]       va_q, va_d;
    logic [31:0]       addr_q, addr_d;
    logic [31:0]       dctl_q, dctl_d;
    logic              store_q, store_d;
    logic              user_q, user_d;
    logic [1:0]        sperm_q, sperm_d;
    logic              ext_q, ext_d;
    logic              coarse_q, coarse_d;
    logic [DOM_IW-1:0] dnum_q, dnum_d;
    logic [1:0]        dval_q, dval_d;
    xlat_res_t         res_q, res_d;

    logic [31:0]       va_rel;
    logic [1:0]        l1_kind;
    logic [DOM_IW-1:0] l1_dnum;
    logic [1:0]        l1_dval;
    logic [31:0]       l1_pa, l1_next;
    logic [1:0]        l1_ap;
    logic              l2_xf;
    logic [31:0]       l2_pa;
    logic [1:0]        l2_ap;
    logic [1:0]        chk_ap, chk_dval;
    logic              g_rd, g_wr;

    xlat_reloc #(.ADDR_W(ADDR_W), .RELOC_LIMIT(RELOC_LIMIT)) u_reloc (
        .va_in(req_va), .offset(pid_offset), .va_out(va_rel)
    );

    xlat_l1_decode u_l1 (
        .desc(mem_rsp_data), .va(va_q), .dom_ctl(dctl_q),
        .kind(l1_kind), .dom_num(l1_dnum), .dom_val(l1_dval),
        .sec_pa(l1_pa), .sec_ap(l1_ap), .l2_addr(l1_next)
    );

    xlat_l2_decode u_l2 (
        .desc(mem_rsp_data), .va(va_q), .coarse(coarse_q), .ext_en(ext_q),
        .xl_fault(l2_xf), .pa(l2_pa), .ap(l2_ap)
    );

    // Share one permission checker between section and page outcomes
    always_comb begin
        if (state_q == S_L1_WAIT) begin
            chk_ap   = l1_ap;
            chk_dval = l1_dval;
        end else begin
            chk_ap   = l2_ap;
            chk_dval = dval_q;
        end
    end

    xlat_perm u_perm (
        .dom_val(chk_dval), .ap(chk_ap), .is_store(store_q), .user(user_q),
        .sys_perm(sperm_q), .rd(g_rd), .wr(g_wr)
    );

    // Build a fault result from a domain number and code
    function automatic xlat_res_t mk_fault(input logic [DOM_IW-1:0] dn, input logic [3:0] code);
        xlat_res_t r;
        r.pa   = '0;
        r.rd   = 1'b0;
        r.wr   = 1'b0;
        r.flt  = 1'b1;
        r.stat = {dn, code};
        return r;
    endfunction

    // Build a successful translation result
    function automatic xlat_res_t mk_ok(input logic [31:0] a, input logic r_g, input logic w_g);
        xlat_res_t r;
        r.pa   = a;
        r.rd   = r_g;
        r.wr   = w_g;
        r.flt  = 1'b0;
        r.stat = '0;
        return r;
    endfunction

    // Walk sequencing and result selection
    always_comb begin
        state_d  = state_q;
        va_d     = va_q;
        addr_d   = addr_q;
        dctl_d   = dctl_q;
        store_d  = store_q;
        user_d   = user_q;
        sperm_d  = sperm_q;
        ext_d    = ext_q;
        coarse_d = coarse_q;
        dnum_d   = dnum_q;
        dval_d   = dval_q;
        res_d    = res_q;
        case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    va_d    = va_rel;
                    dctl_d  = dom_ctl;
                    store_d = (req_acc == ACC_STORE);
                    user_d  = req_user;
                    sperm_d = sys_perm;
                    ext_d   = ext_page_en;
                    addr_d  = {tbl_base[31:14], va_rel[31:20], 2'b00};
                    if (xlat_en) begin
                        state_d = S_L1_REQ;
                    end else begin
                        res_d   = mk_ok(va_rel, 1'b1, 1'b1);
                        state_d = S_DONE;
                    end
                end
            end
            S_L1_REQ: begin
                if (mem_req_ready) state_d = S_L1_WAIT;
            end
            S_L1_WAIT: begin
                if (mem_rsp_valid) begin
                    state_d = S_DONE;
                    if (l1_kind == L1_INVALID) begin
                        res_d = mk_fault(l1_dnum, FC_SEC_XLAT);
                    end else if (l1_dval == 2'd0 || l1_dval == 2'd2) begin
                        res_d = mk_fault(l1_dnum, (l1_kind == L1_SECTION) ? FC_SEC_DOM : FC_PG_DOM);
                    end else if (l1_kind == L1_SECTION) begin
                        if (g_rd || g_wr) res_d = mk_ok(l1_pa, g_rd, g_wr);
                        else              res_d = mk_fault(l1_dnum, FC_SEC_PERM);
                    end else begin
                        addr_d   = l1_next;
                        coarse_d = (l1_kind == L1_COARSE);
                        dnum_d   = l1_dnum;
                        dval_d   = l1_dval;
                        state_d  = S_L2_REQ;
                    end
                end
            end
            S_L2_REQ: begin
                if (mem_req_ready) state_d = S_L2_WAIT;
            end
            S_L2_WAIT: begin
                if (mem_rsp_valid) begin
                    state_d = S_DONE;
                    if (l2_xf)              res_d = mk_fault(dnum_q, FC_PG_XLAT);
                    else if (g_rd || g_wr)  res_d = mk_ok(l2_pa, g_rd, g_wr);
                    else                    res_d = mk_fault(dnum_q, FC_PG_PERM);
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // State and result registers with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            va_q     <= '0;
            addr_q   <= '0;
            dctl_q   <= '0;
            store_q  <= 1'b0;
            user_q   <= 1'b0;
            sperm_q  <= '0;
            ext_q    <= 1'b0;
            coarse_q <= 1'b0;
            dnum_q   <= '0;
            dval_q   <= '0;
            res_q    <= '0;
        end else begin
            state_q  <= state_d;
            va_q     <= va_d;
            addr_q   <= addr_d;
            dctl_q   <= dctl_d;
            store_q  <= store_d;
            user_q   <= user_d;
            sperm_q  <= sperm_d;
            ext_q    <= ext_d;
            coarse_q <= coarse_d;
            dnum_q   <= dnum_d;
            dval_q   <= dval_d;
            res_q    <= res_d;
        end
    end

    // Port drive from state and result registers
    always_comb begin
        req_ready     = (state_q == S_IDLE);
        mem_req_valid = (state_q == S_L1_REQ) || (state_q == S_L2_REQ);
        mem_req_addr  = addr_q;
        done          = (state_q == S_DONE);
        fault         = res_q.flt;
        pa            = res_q.pa;
        prot_rd       = res_q.rd;
        prot_wr       = res_q.wr;
        fault_stat    = res_q.stat;
    end
endmodule

// File: rtl/xlat_walker_chk.sv
// Protocol and result checker for the walker, bound to every instance.
// Assumes the synchronous active-low reset of the walker.
module xlat_walker_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       xlat_en,
    input logic       mem_req_valid,
    input logic       mem_req_ready,
    input logic [31:0] mem_req_addr,
    input logic       done,
    input logic       fault,
    input logic       prot_rd,
    input logic       prot_wr,
    input logic [7:0] fault_stat
);
    logic off_walk;

    // Track a walk accepted with translation disabled
    always_ff @(posedge clk) begin
        if (!rst_n)                      off_walk <= 1'b0;
        else if (req_valid && req_ready) off_walk <= !xlat_en;
        else if (done)                   off_walk <= 1'b0;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R1
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R1
    AST_OFF_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        off_walk |-> !mem_req_valid); // R3
    AST_OFF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !xlat_en) |=> done); // R3
    AST_GRANT_HAS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault) |-> prot_rd); // R12
    AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (!prot_rd && !prot_wr)); // R13
    AST_FAULT_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (fault_stat[3:0] == 4'd5 || fault_stat[3:0] == 4'd7 ||
                             fault_stat[3:0] == 4'd9 || fault_stat[3:0] == 4'd11 ||
                             fault_stat[3:0] == 4'd13 || fault_stat[3:0] == 4'd15)); // R13
    AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R14
endmodule

bind xlat_walker xlat_walker_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .xlat_en(xlat_en), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .done(done), .fault(fault), .prot_rd(prot_rd),
    .prot_wr(prot_wr), .fault_stat(fault_stat)
);

// File: tb/sim_xlat_walker.sv
// Directed bench for the translation walker; one task per scenario.
module sim_xlat_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic [1:0]  req_acc = '0;
    logic        req_user = 1'b0;
    logic [31:0] tbl_base = 32'h0001_4000;
    logic [31:0] dom_ctl = 32'h5555_5555;
    logic [31:0] pid_offset = '0;
    logic        xlat_en = 1'b1;
    logic [1:0]  sys_perm = 2'd0;
    logic        ext_page_en = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done, fault, prot_rd, prot_wr;
    logic [31:0] pa;
    logic [7:0]  fault_stat;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    xlat_walker u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .req_acc(req_acc), .req_user(req_user), .tbl_base(tbl_base),
        .dom_ctl(dom_ctl), .pid_offset(pid_offset), .xlat_en(xlat_en),
        .sys_perm(sys_perm), .ext_page_en(ext_page_en),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .done(done), .fault(fault), .pa(pa),
        .prot_rd(prot_rd), .prot_wr(prot_wr), .fault_stat(fault_stat)
    );

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One walk: drive request, serve up to two descriptor reads, check result
    task automatic walk(input string tag, input logic [31:0] va, input logic [1:0] acc,
                        input logic usr, input int nexp,
                        input logic [31:0] a1, input logic [31:0] d1,
                        input logic [31:0] a2, input logic [31:0] d2,
                        input logic ef, input logic [7:0] es, input logic [31:0] epa,
                        input logic erd, input logic ewr, input int stall);
        int nrd = 0;
        int lat = 0;
        bit seen = 0;
        @(negedge clk);
        chk(req_ready == 1'b1, tag, "ready before request", {31'd0, req_ready}, 32'd1);
        req_va = va; req_acc = acc; req_user = usr; req_valid = 1'b1;
        if (stall > 0) mem_req_ready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int c = 0; c < 40 && !seen; c++) begin
            if (done) begin
                seen = 1;
            end else if (mem_req_valid) begin
                chk(mem_req_addr == ((nrd == 0) ? a1 : a2), tag, "descriptor address",
                    mem_req_addr, (nrd == 0) ? a1 : a2);
                if (stall > 0 && nrd == 0) begin
                    for (int s = 0; s < stall; s++) begin
                        req_valid = 1'b1; req_va = 32'hFFFF_0000;
                        @(posedge clk);
                        @(negedge clk);
                        chk(mem_req_valid && mem_req_addr == a1, "R14", "held request",
                            mem_req_addr, a1);
                        chk(!req_ready, "R1", "ready while busy", {31'd0, req_ready}, 32'd0);
                    end
                    req_valid = 1'b0; req_va = va;
                    mem_req_ready = 1'b1;
                end
                nrd++;
                @(posedge clk);
                @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data = (nrd == 1) ? d1 : d2;
                @(posedge clk);
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                mem_rsp_data = '0;
            end else begin
                lat++;
                @(posedge clk);
                @(negedge clk);
            end
        end
        chk(seen, tag, "done seen", {31'd0, seen}, 32'd1);
        chk(nrd == nexp, "R14", {tag, " read count"}, nrd, nexp);
        if (nexp == 0) chk(lat == 0, "R3", "done latency", lat, 0);
        chk(fault == ef, tag, "fault", {31'd0, fault}, {31'd0, ef});
        chk(fault_stat == es, tag, "fault_stat", {24'd0, fault_stat}, {24'd0, es});
        chk(pa == epa, tag, "pa", pa, epa);
        chk({prot_rd, prot_wr} == {erd, ewr}, tag, "grants",
            {30'd0, prot_rd, prot_wr}, {30'd0, erd, ewr});
        @(posedge clk);
        @(negedge clk);
        chk(!done, "R1", "done single cycle", {31'd0, done}, 32'd0);
    endtask

    localparam logic [31:0] VA  = 32'h1237_8ABC;
    localparam logic [31:0] L1A = 32'h0001_448C;

    task automatic t_reset();
        chk(req_ready && !done && !mem_req_valid, "R1", "reset state",
            {29'd0, req_ready, done, mem_req_valid}, 32'h4);
    endtask

    task automatic t_off();
        xlat_en = 1'b0; pid_offset = 32'h4000_0000;
        walk("R3", 32'h1234_5678, 2'd1, 1'b1, 0, 0, 0, 0, 0, 0, 8'h00, 32'h1234_5678, 1, 1, 0);
        walk("R2", 32'h01FF_FFFC, 2'd0, 1'b0, 0, 0, 0, 0, 0, 0, 8'h00, 32'h41FF_FFFC, 1, 1, 0);
        walk("R2", 32'h0200_0000, 2'd0, 1'b0, 0, 0, 0, 0, 0, 0, 8'h00, 32'h0200_0000, 1, 1, 0);
        xlat_en = 1'b1; pid_offset = '0;
    endtask

    task automatic t_section();
        walk("R7", 32'h1230_0ABC, 2'd1, 1'b1, 1, L1A, 32'h8760_0C22, 0, 0, 0, 8'h00, 32'h8760_0ABC, 1, 1, 0);
        walk("R13", 32'h1230_0ABC, 2'd0, 1'b1, 1, L1A, 32'h8760_0422, 0, 0, 1, 8'h1D, 32'h0, 0, 0, 0);
        pid_offset = 32'h1220_0000;
        walk("R2", 32'h0010_0ABC, 2'd0, 1'b0, 1, L1A, 32'h8760_0C22, 0, 0, 0, 8'h00, 32'h8760_0ABC, 1, 1, 0);
        pid_offset = '0;
        walk("R4", 32'h1230_0ABC, 2'd0, 1'b0, 1, L1A, 32'h8760_0C22, 0, 0, 0, 8'h00, 32'h8760_0ABC, 1, 1, 3);
    endtask

    task automatic t_l1_faults();
        walk("R5", VA, 2'd0, 1'b0, 1, L1A, 32'h0000_0080, 0, 0, 1, 8'h45, 32'h0, 0, 0, 0);
        dom_ctl = 32'h5555_5585;
        walk("R6", VA, 2'd0, 1'b0, 1, L1A, 32'h8760_0C42, 0, 0, 1, 8'h29, 32'h0, 0, 0, 0);
        walk("R6", VA, 2'd0, 1'b0, 1, L1A, 32'h0055_5C61, 0, 0, 1, 8'h3B, 32'h0, 0, 0, 0);
        dom_ctl = 32'h5555_5555;
    endtask

    task automatic t_pages();
        walk("R9", VA, 2'd1, 1'b1, 2, L1A, 32'h0055_5C21, 32'h0055_5DE0, 32'hABCD_E302,
             0, 8'h00, 32'hABCD_EABC, 1, 1, 0);
        walk("R9", 32'h1237_82BC, 2'd0, 1'b0, 2, L1A, 32'h0055_5C21, 32'h0055_5DE0, 32'hABCD_E302,
             1, 8'h1F, 32'h0, 0, 0, 0);
        walk("R9", VA, 2'd0, 1'b0, 2, L1A, 32'h0055_5C21, 32'h0055_5DE0, 32'h7654_0301,
             0, 8'h00, 32'h7654_8ABC, 1, 1, 0);
        walk("R9", VA, 2'd0, 1'b0, 2, L1A, 32'h0055_5C21, 32'h0055_5DE0, 32'h7654_0300,
             1, 8'h17, 32'h0, 0, 0, 0);
        walk("R8", VA, 2'd0, 1'b1, 2, L1A, 32'h0066_7023, 32'h0066_7788, 32'hFEDC_BC23,
             0, 8'h00, 32'hFEDC_BEBC, 1, 0, 0);
        walk("R10", VA, 2'd1, 1'b1, 2, L1A, 32'h0066_7023, 32'h0066_7788, 32'hFEDC_BC23,
             1, 8'h1F, 32'h0, 0, 0, 0);
        walk("R10", VA, 2'd0, 1'b0, 2, L1A, 32'h0055_5C21, 32'h0055_5DE0, 32'hFEDC_BC33,
             1, 8'h17, 32'h0, 0, 0, 0);
        ext_page_en = 1'b1;
        walk("R10", VA, 2'd0, 1'b0, 2, L1A, 32'h0055_5C21, 32'h0055_5DE0, 32'hFEDC_BC33,
             0, 8'h00, 32'hFEDC_BABC, 1, 1, 0);
        ext_page_en = 1'b0;
    endtask

    task automatic t_perm();
        dom_ctl = 32'h5555_555D;
        walk("R11", 32'h1230_0ABC, 2'd1, 1'b1, 1, L1A, 32'h8760_0022, 0, 0, 0, 8'h00, 32'h8760_0ABC, 1, 1, 0);
        dom_ctl = 32'h5555_5555;
        sys_perm = 2'd1;
        walk("R12", 32'h1230_0ABC, 2'd0, 1'b0, 1, L1A, 32'h8760_0022, 0, 0, 0, 8'h00, 32'h8760_0ABC, 1, 0, 0);
        walk("R12", 32'h1230_0ABC, 2'd2, 1'b1, 1, L1A, 32'h8760_0022, 0, 0, 1, 8'h1D, 32'h0, 0, 0, 0);
        sys_perm = 2'd2;
        walk("R12", 32'h1230_0ABC, 2'd0, 1'b1, 1, L1A, 32'h8760_0022, 0, 0, 0, 8'h00, 32'h8760_0ABC, 1, 0, 0);
        walk("R12", 32'h1230_0ABC, 2'd1, 1'b0, 1, L1A, 32'h8760_0022, 0, 0, 1, 8'h1D, 32'h0, 0, 0, 0);
        sys_perm = 2'd0;
        walk("R12", 32'h1230_0ABC, 2'd0, 1'b0, 1, L1A, 32'h8760_0022, 0, 0, 1, 8'h1D, 32'h0, 0, 0, 0);
        walk("R12", 32'h1230_0ABC, 2'd1, 1'b1, 1, L1A, 32'h8760_0822, 0, 0, 1, 8'h1D, 32'h0, 0, 0, 0);
        walk("R12", 32'h1230_0ABC, 2'd0, 1'b1, 1, L1A, 32'h8760_0822, 0, 0, 0, 8'h00, 32'h8760_0ABC, 1, 0, 0);
        walk("R12", 32'h1230_0ABC, 2'd1, 1'b0, 1, L1A, 32'h8760_0822, 0, 0, 0, 8'h00, 32'h8760_0ABC, 1, 1, 0);
        walk("R12", 32'h1230_0ABC, 2'd0, 1'b0, 1, L1A, 32'h8760_0422, 0, 0, 0, 8'h00, 32'h8760_0ABC, 1, 1, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_off();
        t_section();
        t_l1_faults();
        t_pages();
        t_perm();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule